// File: doc/BRIEF.md
# Address-Keyed DRAM Size Limiter

This block produces the eight active-low column strobes for a DRAM array organised as four pairs of CAS lines. A bank decoder upstream raises one pair-select line per cycle. A master CAS request then fires the two lines of that pair. A one-bit mode register decides whether all four pairs can be reached (the full 2MB array) or only the two middle pairs (1MB). When the limit is on, the outer pairs, lines 0/1 and 6/7, are held inactive.

Software changes the mode without any data path. A write bus cycle into one 1MB window of the 24-bit address space updates the register, and the address bit that splits the window into halves gives the new value. The write data is ignored. Reads into the window, and writes anywhere else, leave the register alone. The window normally mirrors ordinary RAM, so software changes the mode with a plain store.

Top module: `ramcap_limit`

## Requirements
- R1: While `rst` is high, and on the first clock edge after it falls, `limit_mode` is 0 and every `cas_n` line is 1.
- R2: A write cycle whose address lies in 0x200000..0x27FFFF clears `limit_mode`. The new value appears after the capturing edge.
- R3: A write cycle whose address lies in 0x280000..0x2FFFFF sets `limit_mode`. Address bit 19 is the value that gets captured.
- R4: A write cycle outside 0x200000..0x2FFFFF leaves `limit_mode` unchanged. All 24 address bits are compared, so 0x1FFFFF, 0x300000 and 0xA80000 all miss.
- R5: A read cycle (`wr`=0) to any address, including both halves of the window, leaves `limit_mode` unchanged.
- R6: Without a qualifying write, `limit_mode` keeps its value for any number of cycles.
- R7: The capture happens only on the first clock of an asserted `bus_strb`. Later clocks of the same held strobe are ignored, even if the address or `wr` changes.
- R8: `cas_n[2p]` and `cas_n[2p+1]` are driven low one clock after an edge where `cas_req`=1, `pair_sel[p]`=1 and pair p is not masked. Otherwise they are high. With `cas_req`=0, all lines are high.
- R9: While `limit_mode` is 1, pairs 0 and 3 (lines 0, 1, 6, 7) are never driven low, and pairs 1 and 2 work as in R8.
- R10: While `limit_mode` is 0, each of the four pairs can be driven low.
- R11: The CAS outputs sample the mode value held before an edge. A CAS request on the same edge as a mode-changing write still sees the old mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 24 | CPU byte address |
| wr | input | 1 | 1 = write cycle, 0 = read cycle |
| bus_strb | input | 1 | High for the duration of a bus cycle |
| cas_req | input | 1 | Master CAS request |
| pair_sel | input | 4 | Pair select from the bank decoder, bit p selects pair p |
| cas_n | output | 8 | Active-low CAS lines, registered |
| limit_mode | output | 1 | 1 = outer pairs masked (1MB), 0 = full array |

## Verification
The properties take every input as synchronous to `clk` and fully driven. This matters most for the upper address bits, which must never float. They also assume that `bus_strb` falls between bus cycles, so that each new cycle starts with a rising strobe. The stimulus drives every input on the falling edge. Between table vectors it inserts an idle cycle with the strobe low, and it keeps `pair_sel` one-hot or zero. Held-strobe cases are applied only by the directed tests, which deliberately change the address and write flag while the strobe stays high.

// File: rtl/ramcap_pkg.sv
package ramcap_pkg;

  typedef enum logic {
    MODE_FULL  = 1'b0,
    MODE_LIMIT = 1'b1
  } ramcap_mode_e;

  // A pair is an outer pair when it sits at either end of the bank order.
  function automatic logic is_outer_pair(input int idx, input int pairs);
    return (idx == 0) || (idx == pairs - 1);
  endfunction

endpackage

// File: rtl/ramcap_window_decode.sv
module ramcap_window_decode #(
  parameter int          ADDR_W   = 24,
  parameter int          WIN_LOG2 = 20,
  parameter logic [23:0] WIN_BASE = 24'h200000
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              in_window,
  output logic              upper_half
);
  localparam logic [ADDR_W-1:0] HI_MASK  = {ADDR_W{1'b1}} << WIN_LOG2;
  localparam logic [ADDR_W-1:0] HALF_BIT = {{(ADDR_W-1){1'b0}}, 1'b1} << (WIN_LOG2 - 1);
  localparam logic [ADDR_W-1:0] BASE     = WIN_BASE[ADDR_W-1:0];

  always_comb begin
    in_window  = ((addr ^ BASE) & HI_MASK) == '0;
    upper_half = (addr & HALF_BIT) != '0;
  end
endmodule

// File: rtl/ramcap_mode_latch.sv
module ramcap_mode_latch
  import ramcap_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         bus_strb,
  input  logic         wr,
  input  logic         in_window,
  input  logic         upper_half,
  output ramcap_mode_e mode
);
  logic strb_q;
  logic take;

  // Only the opening clock of a bus cycle may load the register.
  always_comb take = bus_strb && !strb_q && wr && in_window;

  always_ff @(posedge clk) begin
    if (rst) begin
      strb_q <= 1'b0;
      mode   <= MODE_FULL;
    end else begin
      strb_q <= bus_strb;
      if (take) mode <= upper_half ? MODE_LIMIT : MODE_FULL;
    end
  end
endmodule

// File: rtl/ramcap_cas_gate.sv
module ramcap_cas_gate
  import ramcap_pkg::*;
#(
  parameter int PAIRS = 4,
  parameter int LINES_PER_PAIR = 2
) (
  input  logic                              clk,
  input  logic                              rst,
  input  ramcap_mode_e                      mode,
  input  logic                              cas_req,
  input  logic [PAIRS-1:0]                  pair_sel,
  output logic [PAIRS*LINES_PER_PAIR-1:0]   cas_n
);
  localparam int LINES = PAIRS * LINES_PER_PAIR;

  logic [PAIRS-1:0] fire;

  for (genvar p = 0; p < PAIRS; p++) begin : g_pair
    localparam logic OUTER = is_outer_pair(p, PAIRS);
    logic masked;
    always_comb begin
      masked  = OUTER && (mode == MODE_LIMIT);
      fire[p] = cas_req && pair_sel[p] && !masked;
    end
    always_ff @(posedge clk) begin
      if (rst) cas_n[p*LINES_PER_PAIR +: LINES_PER_PAIR] <= '1;
      else     cas_n[p*LINES_PER_PAIR +: LINES_PER_PAIR] <= {LINES_PER_PAIR{!fire[p]}};
    end
  end

  if (LINES < 2) begin : g_bad
    initial $error("ramcap_cas_gate needs at least one pair");
  end
endmodule

// File: rtl/ramcap_limit.sv
module ramcap_limit
  import ramcap_pkg::*;
#(
  parameter int          ADDR_W   = 24,
  parameter int          PAIRS    = 4,
  parameter int          WIN_LOG2 = 20,
  parameter logic [23:0] WIN_BASE = 24'h200000
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [ADDR_W-1:0]    addr,
  input  logic                 wr,
  input  logic                 bus_strb,
  input  logic                 cas_req,
  input  logic [PAIRS-1:0]     pair_sel,
  output logic [2*PAIRS-1:0]   cas_n,
  output logic                 limit_mode
);
  logic         in_window;
  logic         upper_half;
  ramcap_mode_e mode;

  ramcap_window_decode #(
    .ADDR_W  (ADDR_W),
    .WIN_LOG2(WIN_LOG2),
    .WIN_BASE(WIN_BASE)
  ) u_decode (
    .addr      (addr),
    .in_window (in_window),
    .upper_half(upper_half)
  );

  ramcap_mode_latch u_latch (
    .clk       (clk),
    .rst       (rst),
    .bus_strb  (bus_strb),
    .wr        (wr),
    .in_window (in_window),
    .upper_half(upper_half),
    .mode      (mode)
  );

  ramcap_cas_gate #(
    .PAIRS         (PAIRS),
    .LINES_PER_PAIR(2)
  ) u_gate (
    .clk     (clk),
    .rst     (rst),
    .mode    (mode),
    .cas_req (cas_req),
    .pair_sel(pair_sel),
    .cas_n   (cas_n)
  );

  always_comb limit_mode = (mode == MODE_LIMIT);
endmodule

// File: rtl/ramcap_limit_chk.sv
module ramcap_limit_chk #(
  parameter int          ADDR_W   = 24,
  parameter int          PAIRS    = 4,
  parameter int          WIN_LOG2 = 20,
  parameter logic [23:0] WIN_BASE = 24'h200000
) (
  input logic               clk,
  input logic               rst,
  input logic [ADDR_W-1:0]  addr,
  input logic               wr,
  input logic               bus_strb,
  input logic               cas_req,
  input logic [PAIRS-1:0]   pair_sel,
  input logic [2*PAIRS-1:0] cas_n,
  input logic               limit_mode
);
  localparam logic [ADDR_W-1:0] LO_START = WIN_BASE[ADDR_W-1:0];
  localparam logic [ADDR_W-1:0] HI_START = LO_START + (ADDR_W'(1) << (WIN_LOG2 - 1));
  localparam logic [ADDR_W-1:0] WIN_END  = LO_START + (ADDR_W'(1) << WIN_LOG2);

  logic strb_seen;
  logic lo_hit, hi_hit;

  always_ff @(posedge clk) begin
    if (rst) strb_seen <= 1'b0;
    else     strb_seen <= bus_strb;
  end

  always_comb begin
    lo_hit = (addr >= LO_START) && (addr < HI_START);
    hi_hit = (addr >= HI_START) && (addr < WIN_END);
  end

  AST_RESET_STATE: assert property (@(posedge clk) rst |=> (!limit_mode && (&cas_n))); // R1
  AST_CLEAR_LOWER: assert property (@(posedge clk) disable iff (rst)
    (bus_strb && !strb_seen && wr && lo_hit) |=> !limit_mode); // R2
  AST_SET_UPPER: assert property (@(posedge clk) disable iff (rst)
    (bus_strb && !strb_seen && wr && hi_hit) |=> limit_mode); // R3
  AST_NO_WRITE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(bus_strb && wr && (lo_hit || hi_hit)) |=> $stable(limit_mode)); // R5
  AST_HELD_STROBE: assert property (@(posedge clk) disable iff (rst)
    (bus_strb && strb_seen) |=> $stable(limit_mode)); // R7
  AST_IDLE_CAS: assert property (@(posedge clk) disable iff (rst)
    !cas_req |=> (&cas_n)); // R8
  AST_OUTER_MASK: assert property (@(posedge clk) disable iff (rst)
    limit_mode |=> ((&cas_n[1:0]) && (&cas_n[2*PAIRS-1:2*PAIRS-2]))); // R9

  for (genvar p = 0; p < PAIRS; p++) begin : g_pair_chk
    localparam bit OUTER = (p == 0) || (p == PAIRS - 1);
    AST_PAIR_FIRE: assert property (@(posedge clk) disable iff (rst)
      (cas_req && pair_sel[p] && !(OUTER && limit_mode)) |=> (cas_n[2*p +: 2] == 2'b00)); // R8
    AST_PAIR_QUIET: assert property (@(posedge clk) disable iff (rst)
      !pair_sel[p] |=> (cas_n[2*p +: 2] == 2'b11)); // R8
  end
endmodule

bind ramcap_limit ramcap_limit_chk #(
  .ADDR_W  (ADDR_W),
  .PAIRS   (PAIRS),
  .WIN_LOG2(WIN_LOG2),
  .WIN_BASE(WIN_BASE)
) u_ramcap_chk (
  .clk       (clk),
  .rst       (rst),
  .addr      (addr),
  .wr        (wr),
  .bus_strb  (bus_strb),
  .cas_req   (cas_req),
  .pair_sel  (pair_sel),
  .cas_n     (cas_n),
  .limit_mode(limit_mode)
);

// File: tb/test_ramcap_limit.sv
`timescale 1ns/1ps
module test_ramcap_limit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [23:0] addr = '0;
  logic        wr = 1'b0;
  logic        bus_strb = 1'b0;
  logic        cas_req = 1'b0;
  logic [3:0]  pair_sel = '0;
  logic [7:0]  cas_n;
  logic        limit_mode;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  // Bench model state
  bit m_mode = 1'b0;
  bit m_prev = 1'b0;

  always #5 clk = ~clk;

  ramcap_limit i_ramcap_limit (
    .clk(clk), .rst(rst), .addr(addr), .wr(wr), .bus_strb(bus_strb),
    .cas_req(cas_req), .pair_sel(pair_sel), .cas_n(cas_n), .limit_mode(limit_mode)
  );

  // {addr[23:0], wr, strb, req, sel[3:0]}
  localparam int NV = 20;
  localparam logic [30:0] VECS [NV] = '{
    {24'h280000, 1'b1, 1'b1, 1'b1, 4'b0001}, // R3 set; R11 pair0 still fires on old mode
    {24'h000000, 1'b0, 1'b0, 1'b1, 4'b0001}, // R9 pair0 masked
    {24'h000000, 1'b0, 1'b0, 1'b1, 4'b0010}, // R9 pair1 fires
    {24'h000000, 1'b0, 1'b0, 1'b1, 4'b0100}, // R9 pair2 fires
    {24'h000000, 1'b0, 1'b0, 1'b1, 4'b1000}, // R9 pair3 masked
    {24'h200000, 1'b0, 1'b1, 1'b0, 4'b0000}, // R5 read lower
    {24'h27FFFF, 1'b0, 1'b1, 1'b0, 4'b0000}, // R5 read lower edge
    {24'h1FFFFF, 1'b1, 1'b1, 1'b0, 4'b0000}, // R4 just below
    {24'h300000, 1'b1, 1'b1, 1'b0, 4'b0000}, // R4 just above
    {24'hA80000, 1'b1, 1'b1, 1'b0, 4'b0000}, // R4 upper bit set
    {24'h27FFFF, 1'b1, 1'b1, 1'b0, 4'b0000}, // R2 clear at lower top
    {24'h000000, 1'b0, 1'b0, 1'b1, 4'b1000}, // R10 pair3
    {24'h000000, 1'b0, 1'b0, 1'b1, 4'b0001}, // R10 pair0
    {24'h2FFFFF, 1'b0, 1'b1, 1'b0, 4'b0000}, // R5 read upper
    {24'h1FFFFF, 1'b1, 1'b1, 1'b0, 4'b0000}, // R4 miss while full
    {24'h2FFFFF, 1'b1, 1'b1, 1'b0, 4'b0000}, // R3 set at window top
    {24'h000000, 1'b0, 1'b0, 1'b0, 4'b0010}, // R8 no request
    {24'h000000, 1'b0, 1'b0, 1'b1, 4'b0000}, // R8 no select
    {24'h200000, 1'b1, 1'b1, 1'b1, 4'b1000}, // R2 clear at base; R11 pair3 masked by old mode
    {24'h000000, 1'b0, 1'b0, 1'b1, 4'b1000}  // R10 pair3 after clear
  };

  function automatic logic [7:0] model_cas(bit mode, bit req, logic [3:0] sel);
    logic [7:0] r = 8'hFF;
    for (int p = 0; p < 4; p++) begin
      if (req && sel[p] && !(mode && (p == 0 || p == 3))) r[2*p +: 2] = 2'b00;
    end
    return r;
  endfunction

  // Called at a falling edge; checks at the next falling edge.
  task automatic step(input logic [23:0] a, input bit w, input bit s, input bit r,
                      input logic [3:0] sel, input string tag);
    logic [7:0] exp_cas;
    addr = a; wr = w; bus_strb = s; cas_req = r; pair_sel = sel;
    exp_cas = model_cas(m_mode, r, sel);
    if (s && !m_prev && w && a >= 24'h200000 && a <= 24'h2FFFFF)
      m_mode = (a >= 24'h280000);
    m_prev = s;
    @(posedge clk);
    @(negedge clk);
    vectors++;
    if (cas_n !== exp_cas || limit_mode !== m_mode) begin
      miscompares++;
      $display("FAIL %s addr=%h: cas_n=%b limit_mode=%b expected cas_n=%b limit_mode=%b",
               tag, a, cas_n, limit_mode, exp_cas, m_mode);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    vectors++; // R1 while in reset
    if (cas_n !== 8'hFF || limit_mode !== 1'b0) begin
      miscompares++;
      $display("FAIL R1 in reset: cas_n=%b limit_mode=%b expected 11111111 0", cas_n, limit_mode);
    end
    rst = 1'b0;
    m_mode = 0; m_prev = 0;
    step(24'h0, 0, 0, 0, 4'b0000, "R1 after release");

    for (int i = 0; i < NV; i++) begin
      step(VECS[i][30:7], VECS[i][6], VECS[i][5], VECS[i][4], VECS[i][3:0], "table R2-R11 vector");
      step(24'h0, 0, 0, 0, 4'b0000, "R6 idle hold");
    end

    // R7: held strobe, only the opening clock counts
    step(24'h280000, 1, 1, 0, 4'b0000, "R7 open set");
    step(24'h200000, 1, 1, 0, 4'b0000, "R7 held write lower");
    step(24'h200000, 1, 1, 0, 4'b0000, "R7 held write lower again");
    step(24'h0, 0, 0, 0, 4'b0000, "R7 strobe drop");
    step(24'h200000, 1, 1, 0, 4'b0000, "R2 new cycle clears");
    step(24'h0, 0, 0, 0, 4'b0000, "R6 idle");
    // R7: cycle opens as a read, later turns into an upper write
    step(24'h280000, 0, 1, 0, 4'b0000, "R7 open read");
    step(24'h280000, 1, 1, 0, 4'b0000, "R7 held late write");
    step(24'h0, 0, 0, 0, 4'b0000, "R7 strobe drop");
    // R6: long hold in limit mode
    step(24'h2C0000, 1, 1, 0, 4'b0000, "R3 set mid upper");
    for (int k = 0; k < 6; k++) step(24'h0, 0, 0, 1, 4'b0010, "R6 hold with pair1");
    // R1: reset out of limit mode
    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    rst = 1'b0;
    m_mode = 0; m_prev = 0;
    vectors++;
    if (limit_mode !== 1'b0 || cas_n !== 8'hFF) begin
      miscompares++;
      $display("FAIL R1 reset from limit: cas_n=%b limit_mode=%b expected 11111111 0", cas_n, limit_mode);
    end
    step(24'h0, 0, 0, 1, 4'b0001, "R10 pair0 after reset");
    done = 1'b1;
    finish_run();
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: run did not complete, expected completion within 5000 cycles");
      finish_run();
    end
  end
endmodule